// File: doc/BRIEF.md
# Test Engine Selector Wrapper

This block sits between one memory-mapped master port and three memory test engines (a read/write stream engine, a loopback engine and an atomic-operation engine). A start pulse with a mode code picks one engine and kicks it off. From then until that engine reports done, only the chosen engine reaches the upstream port. Because at most one engine is ever active, the block selects a path and never arbitrates.

When the chosen engine signals done, the wrapper takes the upstream port for itself. It posts one write that carries a completion record to a status address. After that write's response returns, it goes idle and, if the caller asked for it at start, pulses an interrupt for one cycle. The port structure depends only on the width parameters, so the same module serves a host-memory port or a local-memory port without change.

Top module: `test_engine_mux`

## Requirements
- R1: After reset, `busy`, `irq` and `eng_start` are 0 and no upstream request valid is asserted.
- R2: A `start` pulse while idle, with `mode` set to 0 (read/write), 1 (loopback) or 2 (atomic), raises bit `mode` of `eng_start` for exactly the one cycle after the start edge and sets `busy`. Mode 3 is ignored: `busy` stays 0 and no `eng_start` bit rises.
- R3: `mode`, `irq_en` and `status_addr` are captured at start. While `busy`, a new `start` or a changed `mode` starts nothing and does not change the routing.
- R4: While the selected engine runs, the upstream AW, W and AR channels and the B/R ready signals carry that engine's signals. The upstream ready and response valid signals reach only that engine.
- R5: Engines that are not selected see their `awready`, `wready`, `arready`, `bvalid` and `rvalid` held at 0. While idle, all engines see these signals at 0.
- R6: A done from an unselected engine is ignored. Done from the selected engine leads to exactly one upstream write to the captured status address with ID 0 and `wlast`=1. The write data has bit 0 = 1 (done flag), bits [CW:1] = that engine's `eng_count` slice, and all higher bits 0.
- R7: The completion address and data beat can be accepted in the same cycle or in either order. Each is presented only until it is accepted.
- R8: `busy` drops at the edge where the completion write response is accepted. `irq` is high for the following single cycle only if `irq_en` was 1 at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| mode | input | 2 | Engine code: 0 rd/wr, 1 loopback, 2 atomic |
| irq_en | input | 1 | Request interrupt on completion |
| status_addr | input | AW | Completion record address |
| busy | output | 1 | Test in progress |
| irq | output | 1 | Completion interrupt pulse |
| eng_start | output | 3 | One-cycle start per engine |
| eng_done | input | 3 | Done per engine |
| eng_count | input | 3*CW | Completed transaction count per engine |
| e_awvalid | input | 3 | Engine write address valid |
| e_awready | output | 3 | Engine write address ready |
| e_awaddr | input | 3*AW | Engine write addresses |
| e_awid | input | 3*IW | Engine write IDs |
| e_wvalid | input | 3 | Engine write data valid |
| e_wready | output | 3 | Engine write data ready |
| e_wdata | input | 3*DW | Engine write data |
| e_wlast | input | 3 | Engine last beat |
| e_bvalid | output | 3 | Write response valid per engine |
| e_bready | input | 3 | Engine write response ready |
| e_bid | output | IW | Write response ID (shared) |
| e_arvalid | input | 3 | Engine read address valid |
| e_arready | output | 3 | Engine read address ready |
| e_araddr | input | 3*AW | Engine read addresses |
| e_arid | input | 3*IW | Engine read IDs |
| e_rvalid | output | 3 | Read data valid per engine |
| e_rready | input | 3 | Engine read data ready |
| e_rdata | output | DW | Read data (shared) |
| e_rid | output | IW | Read ID (shared) |
| e_rlast | output | 1 | Read last (shared) |
| m_awvalid | output | 1 | Upstream write address valid |
| m_awready | input | 1 | Upstream write address ready |
| m_awaddr | output | AW | Upstream write address |
| m_awid | output | IW | Upstream write ID |
| m_wvalid | output | 1 | Upstream write data valid |
| m_wready | input | 1 | Upstream write data ready |
| m_wdata | output | DW | Upstream write data |
| m_wlast | output | 1 | Upstream last beat |
| m_bvalid | input | 1 | Upstream write response valid |
| m_bready | output | 1 | Upstream write response ready |
| m_bid | input | IW | Upstream write response ID |
| m_arvalid | output | 1 | Upstream read address valid |
| m_arready | input | 1 | Upstream read address ready |
| m_araddr | output | AW | Upstream read address |
| m_arid | output | IW | Upstream read ID |
| m_rvalid | input | 1 | Upstream read data valid |
| m_rready | output | 1 | Upstream read data ready |
| m_rdata | input | DW | Upstream read data |
| m_rid | input | IW | Upstream read ID |
| m_rlast | input | 1 | Upstream read last |

## Verification
A corrupted selection register shows up at once: in the same cycle, the upstream address and the engine-side ready bits follow the wrong engine. A slip in the completion sequencer shows at the ports within one or two cycles. It appears as an address or data beat that stays valid after acceptance, a record holding the wrong engine's count, or `busy`/`irq` changing on the wrong edge. The bench therefore samples routing combinationally in every run. It checks the completion handshake edge by edge under all three acceptance orders.

// File: rtl/test_engine_mux.sv
module test_engine_mux #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int IW = 4,
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             irq_en,
  input  logic [AW-1:0]    status_addr,
  output logic             busy,
  output logic             irq,
  output logic [2:0]       eng_start,
  input  logic [2:0]       eng_done,
  input  logic [3*CW-1:0]  eng_count,
  input  logic [2:0]       e_awvalid,
  output logic [2:0]       e_awready,
  input  logic [3*AW-1:0]  e_awaddr,
  input  logic [3*IW-1:0]  e_awid,
  input  logic [2:0]       e_wvalid,
  output logic [2:0]       e_wready,
  input  logic [3*DW-1:0]  e_wdata,
  input  logic [2:0]       e_wlast,
  output logic [2:0]       e_bvalid,
  input  logic [2:0]       e_bready,
  output logic [IW-1:0]    e_bid,
  input  logic [2:0]       e_arvalid,
  output logic [2:0]       e_arready,
  input  logic [3*AW-1:0]  e_araddr,
  input  logic [3*IW-1:0]  e_arid,
  output logic [2:0]       e_rvalid,
  input  logic [2:0]       e_rready,
  output logic [DW-1:0]    e_rdata,
  output logic [IW-1:0]    e_rid,
  output logic             e_rlast,
  output logic             m_awvalid,
  input  logic             m_awready,
  output logic [AW-1:0]    m_awaddr,
  output logic [IW-1:0]    m_awid,
  output logic             m_wvalid,
  input  logic             m_wready,
  output logic [DW-1:0]    m_wdata,
  output logic             m_wlast,
  input  logic             m_bvalid,
  output logic             m_bready,
  input  logic [IW-1:0]    m_bid,
  output logic             m_arvalid,
  input  logic             m_arready,
  output logic [AW-1:0]    m_araddr,
  output logic [IW-1:0]    m_arid,
  input  logic             m_rvalid,
  output logic             m_rready,
  input  logic [DW-1:0]    m_rdata,
  input  logic [IW-1:0]    m_rid,
  input  logic             m_rlast
);

  localparam int NE = 3;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_CPL, S_WAITB} st_t;

  st_t            st;
  logic [1:0]     sel;
  logic           irq_en_q;
  logic [AW-1:0]  addr_q;
  logic [CW-1:0]  cnt_q;
  logic           aw_sent, w_sent;
  logic [NE-1:0]  gsel;
  logic [CW-1:0]  sel_cnt;

  wire run   = (st == S_RUN);
  wire cpl   = (st == S_CPL);
  wire waitb = (st == S_WAITB);
  wire go    = (st == S_IDLE) && start && (mode != 2'd3);
  wire fin   = |(eng_done & gsel);
  wire aw_hs = cpl && m_awvalid && m_awready;
  wire w_hs  = cpl && m_wvalid && m_wready;

  assign busy = (st != S_IDLE);
  assign gsel = run ? (NE'(1) << sel) : '0;

  always_comb begin
    sel_cnt = '0;
    for (int i = 0; i < NE; i++)
      if (gsel[i]) sel_cnt = eng_count[i*CW +: CW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sel       <= '0;
      irq_en_q  <= 1'b0;
      addr_q    <= '0;
      cnt_q     <= '0;
      aw_sent   <= 1'b0;
      w_sent    <= 1'b0;
      irq       <= 1'b0;
      eng_start <= '0;
    end else begin
      irq       <= 1'b0;
      eng_start <= go ? (NE'(1) << mode) : '0;
      case (st)
        S_IDLE: if (go) begin
          sel      <= mode;
          irq_en_q <= irq_en;
          addr_q   <= status_addr;
          st       <= S_RUN;
        end
        S_RUN: if (fin) begin
          cnt_q   <= sel_cnt;
          aw_sent <= 1'b0;
          w_sent  <= 1'b0;
          st      <= S_CPL;
        end
        S_CPL: begin
          if (aw_hs) aw_sent <= 1'b1;
          if (w_hs)  w_sent  <= 1'b1;
          if ((aw_sent || aw_hs) && (w_sent || w_hs)) st <= S_WAITB;
        end
        S_WAITB: if (m_bvalid) begin
          irq <= irq_en_q;
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    m_awvalid = 1'b0;
    m_awaddr  = '0;
    m_awid    = '0;
    m_wvalid  = 1'b0;
    m_wdata   = '0;
    m_wlast   = 1'b0;
    m_bready  = 1'b0;
    m_arvalid = 1'b0;
    m_araddr  = '0;
    m_arid    = '0;
    m_rready  = 1'b0;
    for (int i = 0; i < NE; i++) begin
      if (gsel[i]) begin
        m_awvalid = e_awvalid[i];
        m_awaddr  = e_awaddr[i*AW +: AW];
        m_awid    = e_awid[i*IW +: IW];
        m_wvalid  = e_wvalid[i];
        m_wdata   = e_wdata[i*DW +: DW];
        m_wlast   = e_wlast[i];
        m_bready  = e_bready[i];
        m_arvalid = e_arvalid[i];
        m_araddr  = e_araddr[i*AW +: AW];
        m_arid    = e_arid[i*IW +: IW];
        m_rready  = e_rready[i];
      end
    end
    if (cpl) begin
      m_awvalid     = !aw_sent;
      m_awaddr      = addr_q;
      m_wvalid      = !w_sent;
      m_wdata[CW:0] = {cnt_q, 1'b1};
      m_wlast       = 1'b1;
    end
    if (waitb) m_bready = 1'b1;
  end

  assign e_awready = gsel & {NE{m_awready}};
  assign e_wready  = gsel & {NE{m_wready}};
  assign e_arready = gsel & {NE{m_arready}};
  assign e_bvalid  = gsel & {NE{m_bvalid}};
  assign e_rvalid  = gsel & {NE{m_rvalid}};
  assign e_bid     = m_bid;
  assign e_rdata   = m_rdata;
  assign e_rid     = m_rid;
  assign e_rlast   = m_rlast;

  a_r2_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_start));

  a_r2_start_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_start) |-> busy && !$past(busy));

  a_r3_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sel));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (e_awready == '0 && e_wready == '0 && e_arready == '0 &&
               e_bvalid == '0 && e_rvalid == '0 && !m_awvalid && !m_arvalid));

  a_r6_cpl_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl && !$past(cpl)) |-> $past(run));

  a_r7_aw_once: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl && $past(aw_hs)) |-> !m_awvalid);

  a_r7_w_once: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl && $past(w_hs)) |-> !m_wvalid);

  a_r8_irq_after_b: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(m_bvalid && m_bready) && !busy));

endmodule

// File: tb/test_engine_mux_test.sv
module test_engine_mux_test;
  localparam int AW = 32, DW = 64, IW = 4, CW = 32;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic start = 0, irq_en = 0;
  logic [1:0] mode = 0;
  logic [AW-1:0] status_addr = 0;
  logic busy, irq;
  logic [2:0] eng_start, eng_done = 0;
  logic [3*CW-1:0] eng_count = 0;
  logic [2:0] e_awvalid = 0, e_wvalid = 0, e_wlast = 0, e_bready = 0, e_arvalid = 0, e_rready = 0;
  logic [2:0] e_awready, e_wready, e_bvalid, e_arready, e_rvalid;
  logic [3*AW-1:0] e_awaddr = 0, e_araddr = 0;
  logic [3*IW-1:0] e_awid = 0, e_arid = 0;
  logic [3*DW-1:0] e_wdata = 0;
  logic [IW-1:0] e_bid, e_rid, m_awid, m_arid;
  logic [DW-1:0] e_rdata, m_wdata;
  logic e_rlast;
  logic m_awvalid, m_wvalid, m_wlast, m_bready, m_arvalid, m_rready;
  logic m_awready = 0, m_wready = 0, m_bvalid = 0, m_arready = 0, m_rvalid = 0, m_rlast = 0;
  logic [AW-1:0] m_awaddr, m_araddr;
  logic [IW-1:0] m_bid = 0, m_rid = 0;
  logic [DW-1:0] m_rdata = 0;

  test_engine_mux #(.AW(AW), .DW(DW), .IW(IW), .CW(CW)) uut (.*);

  int n_run = 0, n_fail = 0, aw_cnt = 0, w_cnt = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (m_awvalid && m_awready) aw_cnt++;
    if (m_wvalid && m_wready) w_cnt++;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // {mode[2], irq_en[1], order[2], count[32], addr[32]}; order 0 same, 1 AW first, 2 W first
  localparam logic [68:0] VEC [6] = '{
    {2'd0, 1'b1, 2'd0, 32'h0000_0005, 32'h1000_0040},
    {2'd1, 1'b0, 2'd1, 32'h0001_2345, 32'h2000_0080},
    {2'd2, 1'b1, 2'd2, 32'hFFFF_FFFF, 32'h3000_00C0},
    {2'd1, 1'b1, 2'd2, 32'h0000_0000, 32'h4000_0100},
    {2'd0, 1'b0, 2'd1, 32'h8000_0001, 32'h5000_0140},
    {2'd2, 1'b0, 2'd0, 32'h0000_00AA, 32'h6000_0180}
  };

  task automatic run_one(input logic [68:0] v);
    logic [1:0] md = v[68:67];
    logic ie = v[66];
    logic [1:0] ord = v[65:64];
    logic [31:0] cnt = v[63:32];
    logic [31:0] ad = v[31:0];
    int a0, w0;
    logic [1:0] other = (md == 2'd2) ? 2'd0 : md + 2'd1;
    for (int i = 0; i < 3; i++) eng_count[i*CW +: CW] = (i == md) ? cnt : ~cnt ^ 32'(i);
    mode = md; irq_en = ie; status_addr = ad; start = 1;
    step(); start = 0; mode = 2'd3; irq_en = ~ie; status_addr = 32'hDEAD_0000;
    chk("R2 eng_start", 64'(eng_start), 64'(3'b001 << md));
    chk("R2 busy", 64'(busy), 64'd1);
    step();
    chk("R2 eng_start pulse", 64'(eng_start), 64'd0);
    for (int i = 0; i < 3; i++) begin
      e_arvalid[i] = 1; e_araddr[i*AW +: AW] = 32'hA000_0000 + 32'(i);
      e_awvalid[i] = 1; e_awaddr[i*AW +: AW] = 32'hB000_0000 + 32'(i);
    end
    m_arready = 1; m_rvalid = 1; m_awready = 1; m_bvalid = 0;
    #1;
    chk("R4 araddr", 64'(m_araddr), 64'(32'hA000_0000 + 32'(md)));
    chk("R4 awaddr", 64'(m_awaddr), 64'(32'hB000_0000 + 32'(md)));
    chk("R5 arready", 64'(e_arready), 64'(3'b001 << md));
    chk("R5 rvalid", 64'(e_rvalid), 64'(3'b001 << md));
    step();
    e_arvalid = 0; e_awvalid = 0; m_arready = 0; m_rvalid = 0; m_awready = 0;
    eng_done = 3'b001 << other;
    step(); eng_done = 0;
    chk("R6 wrong done ignored", 64'({busy, m_awvalid}), 64'b10);
    a0 = aw_cnt; w0 = w_cnt;
    eng_done = 3'b001 << md;
    step(); eng_done = 0;
    chk("R6 awvalid", 64'({m_awvalid, m_wvalid, m_wlast}), 64'b111);
    chk("R6 awaddr", 64'(m_awaddr), 64'(ad));
    chk("R6 awid", 64'(m_awid), 64'd0);
    chk("R6 record", m_wdata, {31'd0, cnt, 1'b1});
    if (ord == 2'd0) begin
      m_awready = 1; m_wready = 1; step();
    end else if (ord == 2'd1) begin
      m_awready = 1; step(); m_awready = 0;
      chk("R7 aw first", 64'({m_awvalid, m_wvalid}), 64'b01);
      step();
      chk("R7 w held", 64'({m_awvalid, m_wvalid}), 64'b01);
      m_wready = 1; step();
    end else begin
      m_wready = 1; step(); m_wready = 0;
      chk("R7 w first", 64'({m_awvalid, m_wvalid}), 64'b10);
      m_awready = 1; step();
    end
    m_awready = 0; m_wready = 0;
    chk("R7 one aw one w", 64'({aw_cnt - a0, w_cnt - w0}), {32'd1, 32'd1});
    chk("R8 busy before b", 64'({busy, m_awvalid, m_wvalid, m_bready}), 64'b1001);
    m_bvalid = 1;
    step(); m_bvalid = 0;
    chk("R8 busy/irq", 64'({busy, irq}), 64'({1'b0, ie}));
    step();
    chk("R8 irq single", 64'(irq), 64'd0);
  endtask

  initial begin
    repeat (3) step();
    chk("R1 reset", 64'({busy, irq, eng_start, m_awvalid, m_wvalid, m_arvalid}), 64'd0);
    rst_n = 1;
    step();
    chk("R1 after release", 64'({busy, irq, eng_start}), 64'd0);
    m_arready = 1; m_rvalid = 1; m_bvalid = 1; m_awready = 1; e_arvalid = 3'b111; #1;
    chk("R5 idle quiet", 64'({e_arready, e_rvalid, e_bvalid, e_awready, m_arvalid}), 64'd0);
    m_arready = 0; m_rvalid = 0; m_bvalid = 0; m_awready = 0; e_arvalid = 0;
    mode = 2'd3; start = 1; step(); start = 0;
    chk("R2 mode3 ignored", 64'({busy, eng_start}), 64'd0);
    step();
    chk("R2 mode3 still idle", 64'(busy), 64'd0);
    for (int k = 0; k < 6; k++) run_one(VEC[k]);
    mode = 2'd0; irq_en = 1; status_addr = 32'h7000_0000; start = 1;
    step(); start = 0; step();
    mode = 2'd2; start = 1; step(); start = 0;
    chk("R3 restart ignored", 64'(eng_start), 64'd0);
    e_arvalid = 3'b100; e_araddr = {32'hC2, 32'hC1, 32'hC0}; e_arvalid[0] = 1; m_arready = 1; #1;
    chk("R3 routing kept", 64'({e_arready, m_araddr}), {29'd0, 3'b001, 32'hC0});
    m_arready = 0; e_arvalid = 0;
    eng_done = 3'b100; step(); eng_done = 0;
    chk("R3 new mode done ignored", 64'({busy, m_awvalid}), 64'b10);
    eng_done = 3'b001; step(); eng_done = 0;
    chk("R3 captured addr", 64'(m_awaddr), 64'h7000_0000);
    m_awready = 1; m_wready = 1; step(); m_awready = 0; m_wready = 0;
    m_bvalid = 1; step(); m_bvalid = 0;
    chk("R8 captured irq_en", 64'({busy, irq}), 64'b01);
    step();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule